// File: doc/BRIEF.md
# Seconds Watchdog with Reset Pulse

This block is a watchdog timer programmed through a small bank of byte-wide registers. Software loads a timeout into an 8-bit count register. While the block is switched on and the count is nonzero, the count falls by one on every seconds tick. When it steps from 1 to 0, the block raises a sticky status flag. If pulse output is enabled, it also drives a fixed-length active-low pulse onto a keyboard-reset output.

A count of zero means the watchdog is stopped, and a nonzero count means it is running. Writing the count register with any value restarts the timeout from that value. Writing zero stops it quietly. Keyboard or mouse activity can each be enabled to restart a running count from the last loaded timeout. A mode bit slows the countdown to once per sixty ticks. A global activate bit freezes the whole timer while it is clear. The seconds tick is an input that is high for one clock cycle.

Top module: `seconds_wdt`

## Requirements
- R1: After reset, every register reads 0: activate at 0x30, mode at 0xF5, count at 0xF6, and enables/status at 0xF7. Unmapped addresses also read 0, and `kbrst_no` is high.
- R2: A write to 0xF6 loads the count and records the value as the reload timeout. A read of 0xF6 returns the current remaining count.
- R3: With activate set (0x30 bit 0), mode bit 3 of 0xF5 clear and a nonzero count, each `tick_i` pulse lowers the count by exactly one.
- R4: With 0xF5 bit 3 set (minute mode), the count falls by one only on every 60th tick since the last load or reload.
- R5: When the count steps from 1 to 0 and 0xF5 bit 1 is set, `kbrst_no` goes low from the next cycle for exactly 16 clock cycles.
- R6: When the count steps from 1 to 0 and 0xF5 bit 1 is clear, `kbrst_no` stays high.
- R7: Writing 0 to 0xF6 stops the watchdog. No pulse follows and the status flag is not set.
- R8: While 0x30 bit 0 is clear, ticks and activity leave the count unchanged and produce no pulse.
- R9: On a running count, `kb_act_i` reloads the timeout when 0xF7 bit 7 is set, and `ms_act_i` reloads it when 0xF7 bit 6 is set. Activity whose enable bit is clear is ignored.
- R10: 0xF7 bit 4 becomes 1 when the count expires. A write to 0xF7 with bit 4 set clears it, and a write with bit 4 clear leaves it unchanged.
- R11: A zero count ignores ticks and activity and stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tick_i | input | 1 | Seconds tick, one cycle wide |
| kb_act_i | input | 1 | Keyboard activity strobe |
| ms_act_i | input | 1 | Mouse activity strobe |
| kbrst_no | output | 1 | Active-low timeout pulse |

## Verification
The bench goes after the 1-to-0 step under each setting of the pulse enable. A design that fires on the wrong edge, or ignores the enable, gives a pulse of the wrong length or a pulse where none belongs. Writing zero to a running count has to stop it with no flag and no pulse; a design that treats the stop as an expiry would reset the host. The minute prescaler is checked right at the 59th and 60th ticks, where an off-by-one shows up directly in the count. Activity is applied with its enable both clear and set, so a design that reloads unconditionally, or reloads while frozen or stopped, returns the wrong remaining time.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam logic [7:0] ADDR_ACT  = 8'h30;
  localparam logic [7:0] ADDR_MODE = 8'hF5;
  localparam logic [7:0] ADDR_CNT  = 8'hF6;
  localparam logic [7:0] ADDR_EN   = 8'hF7;

  typedef struct packed {
    logic active;
    logic minute;
    logic aux;
    logic pulse_en;
    logic kb_en;
    logic ms_en;
  } cfg_t;
endpackage

// File: rtl/swd_regs.sv
module swd_regs
  import swd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              expire_i,
  input  logic [DATA_W-1:0] cnt_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rdata_o
);
  cfg_t cfg_q;
  logic status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          ADDR_ACT:  cfg_q.active <= wdata_i[0];
          ADDR_MODE: begin
            cfg_q.minute   <= wdata_i[3];
            cfg_q.aux      <= wdata_i[2];
            cfg_q.pulse_en <= wdata_i[1];
          end
          ADDR_EN: begin
            cfg_q.kb_en <= wdata_i[7];
            cfg_q.ms_en <= wdata_i[6];
          end
          default: ;
        endcase
      end
      // expiry wins over a same-cycle clear
      if (expire_i) status_q <= 1'b1;
      else if (we_i && addr_i == ADDR_EN && wdata_i[4]) status_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_ACT:  rdata_o[0] = cfg_q.active;
      ADDR_MODE: rdata_o[3:1] = {cfg_q.minute, cfg_q.aux, cfg_q.pulse_en};
      ADDR_CNT:  rdata_o = cnt_i;
      ADDR_EN:   begin
        rdata_o[7] = cfg_q.kb_en;
        rdata_o[6] = cfg_q.ms_en;
        rdata_o[4] = status_q;
      end
      default: ;
    endcase
  end

  assign cfg_o = cfg_q;

  assert_status_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> status_q);
endmodule

// File: rtl/swd_counter.sv
module swd_counter #(
  parameter int DATA_W    = 8,
  parameter int MIN_TICKS = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              minute_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic              act_hit_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              expire_o
);
  localparam int PRE_W = (MIN_TICKS > 1) ? $clog2(MIN_TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MIN_TICKS - 1);

  logic [DATA_W-1:0] cnt_q, reload_q;
  logic [PRE_W-1:0]  pre_q;
  logic run, reload, tick_run, step;

  assign run      = active_i && (cnt_q != '0);
  assign reload   = !ld_i && run && act_hit_i;
  assign tick_run = !ld_i && !reload && run && tick_i;
  assign step     = tick_run && (!minute_i || pre_q == PRE_LAST);
  assign expire_o = step && (cnt_q == DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      pre_q    <= '0;
    end else if (ld_i) begin
      cnt_q    <= ld_val_i;
      reload_q <= ld_val_i;
      pre_q    <= '0;
    end else if (reload) begin
      cnt_q <= reload_q;
      pre_q <= '0;
    end else if (tick_run) begin
      if (minute_i) pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (step) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  assert_hold_inactive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !ld_i) |=> $stable(cnt_q));
  assert_zero_stays_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !ld_i) |=> cnt_q == '0);
  assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !act_hit_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/swd_pulse.sv
module swd_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic en_i,
  output logic pulse_no
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                left_q <= '0;
    else if (expire_i && en_i)  left_q <= PW'(PULSE_CYCLES);
    else if (left_q != '0)      left_q <= left_q - 1'b1;
  end

  assign pulse_no = (left_q == '0);

  assert_pulse_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_no) |-> $past(expire_i && en_i));
endmodule

// File: rtl/seconds_wdt.sv
module seconds_wdt
  import swd_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int MIN_TICKS    = 60,
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              kb_act_i,
  input  logic              ms_act_i,
  output logic              kbrst_no
);
  cfg_t cfg;
  logic [DATA_W-1:0] cnt;
  logic expire, act_hit, ld;

  assign ld      = we_i && (addr_i == ADDR_CNT);
  assign act_hit = (kb_act_i && cfg.kb_en) || (ms_act_i && cfg.ms_en);

  swd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .expire_i(expire), .cnt_i(cnt), .cfg_o(cfg), .rdata_o
  );

  swd_counter #(.DATA_W(DATA_W), .MIN_TICKS(MIN_TICKS)) u_cnt (
    .clk_i, .rst_ni, .active_i(cfg.active), .minute_i(cfg.minute),
    .ld_i(ld), .ld_val_i(wdata_i), .act_hit_i(act_hit), .tick_i,
    .cnt_o(cnt), .expire_o(expire)
  );

  swd_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i, .rst_ni, .expire_i(expire), .en_i(cfg.pulse_en), .pulse_no(kbrst_no)
  );
endmodule

// File: tb/seconds_wdt_test.sv
module seconds_wdt_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic we = 1'b0, tick = 1'b0, kb = 1'b0, ms = 1'b0, kbrst_n;

  int checks = 0, failures = 0, low_cnt = 0;
  string phase = "R1";

  // reference model state
  int m_act, m_min, m_aux, m_pen, m_kbe, m_mse, m_st, m_cnt, m_rel, m_pre, m_pl;

  always #2 clk = ~clk;

  seconds_wdt uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .tick_i(tick), .kb_act_i(kb), .ms_act_i(ms), .kbrst_no(kbrst_n)
  );

  function automatic int model_read(input logic [7:0] a);
    case (a)
      8'h30: return m_act;
      8'hF5: return (m_min << 3) | (m_aux << 2) | (m_pen << 1);
      8'hF6: return m_cnt;
      8'hF7: return (m_kbe << 7) | (m_mse << 6) | (m_st << 4);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_min = 0; m_aux = 0; m_pen = 0; m_kbe = 0; m_mse = 0;
      m_st = 0; m_cnt = 0; m_rel = 0; m_pre = 0; m_pl = 0;
    end else begin
      int ex;
      ex = 0;
      if (we && addr == 8'hF6) begin
        m_cnt = wdata; m_rel = wdata; m_pre = 0;
      end else if (m_act == 1 && m_cnt != 0 && ((kb && m_kbe == 1) || (ms && m_mse == 1))) begin
        m_cnt = m_rel; m_pre = 0;
      end else if (m_act == 1 && m_cnt != 0 && tick) begin
        int dec;
        dec = 1;
        if (m_min == 1) begin
          if (m_pre == 59) m_pre = 0;
          else begin m_pre++; dec = 0; end
        end
        if (dec == 1) begin
          if (m_cnt == 1) ex = 1;
          m_cnt--;
        end
      end
      if (ex == 1 && m_pen == 1) m_pl = 16;
      else if (m_pl > 0) m_pl--;
      if (ex == 1) m_st = 1;
      else if (we && addr == 8'hF7 && wdata[4]) m_st = 0;
      if (we) begin
        case (addr)
          8'h30: m_act = wdata[0];
          8'hF5: begin m_min = wdata[3]; m_aux = wdata[2]; m_pen = wdata[1]; end
          8'hF7: begin m_kbe = wdata[7]; m_mse = wdata[6]; end
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      checks++;
      if (kbrst_n !== (m_pl == 0)) begin
        failures++;
        $display("FAIL %s kbrst_no actual=%0b expected=%0b", phase, kbrst_n, m_pl == 0);
      end
      checks++;
      if (rdata !== 8'(model_read(addr))) begin
        failures++;
        $display("FAIL %s rdata@%02h actual=%02h expected=%02h", phase, addr, rdata, model_read(addr));
      end
      if (!kbrst_n) low_cnt++;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input int exp);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    phase = "R1";
    check("R1 kbrst_no", kbrst_n, 1);
    rd_chk("R1 act", 8'h30, 0);
    rd_chk("R1 mode", 8'hF5, 0);
    rd_chk("R1 cnt", 8'hF6, 0);
    rd_chk("R1 en", 8'hF7, 0);
    rd_chk("R1 unmapped", 8'h42, 0);

    phase = "R2";
    wr(8'h30, 8'h01);
    wr(8'hF5, 8'h02);
    wr(8'hF6, 8'd5);
    rd_chk("R2 load", 8'hF6, 5);
    phase = "R3";
    ticks(3);
    rd_chk("R3 three ticks", 8'hF6, 2);

    phase = "R5";
    low_cnt = 0;
    ticks(2);
    idle(25);
    check("R5 pulse width", low_cnt, 16);
    phase = "R10";
    rd_chk("R10 status set", 8'hF7, 8'h10);
    wr(8'hF7, 8'h00);
    rd_chk("R10 write0 keeps", 8'hF7, 8'h10);
    wr(8'hF7, 8'h10);
    rd_chk("R10 write1 clears", 8'hF7, 8'h00);

    phase = "R6";
    wr(8'hF5, 8'h00);
    wr(8'hF6, 8'd1);
    low_cnt = 0;
    ticks(1);
    idle(20);
    check("R6 no pulse", low_cnt, 0);
    rd_chk("R6 status", 8'hF7, 8'h10);
    wr(8'hF7, 8'h10);

    phase = "R7";
    wr(8'hF5, 8'h02);
    wr(8'hF6, 8'd3);
    ticks(1);
    low_cnt = 0;
    wr(8'hF6, 8'd0);
    phase = "R11";
    ticks(4);
    idle(20);
    check("R7 no pulse", low_cnt, 0);
    rd_chk("R7 no status", 8'hF7, 0);
    rd_chk("R11 zero stays", 8'hF6, 0);

    phase = "R8";
    wr(8'h30, 8'h00);
    wr(8'hF7, 8'hC0);
    wr(8'hF6, 8'd4);
    ticks(5);
    @(negedge clk); kb = 1'b1;
    @(negedge clk); kb = 1'b0;
    rd_chk("R8 frozen", 8'hF6, 4);
    wr(8'h30, 8'h01);
    wr(8'hF7, 8'h00);

    phase = "R9";
    wr(8'hF6, 8'd5);
    ticks(2);
    @(negedge clk); kb = 1'b1;
    @(negedge clk); kb = 1'b0;
    rd_chk("R9 kb ignored", 8'hF6, 3);
    wr(8'hF7, 8'h80);
    @(negedge clk); kb = 1'b1;
    @(negedge clk); kb = 1'b0;
    rd_chk("R9 kb reload", 8'hF6, 5);
    ticks(1);
    @(negedge clk); ms = 1'b1;
    @(negedge clk); ms = 1'b0;
    rd_chk("R9 ms ignored", 8'hF6, 4);
    wr(8'hF7, 8'h40);
    @(negedge clk); ms = 1'b1;
    @(negedge clk); ms = 1'b0;
    rd_chk("R9 ms reload", 8'hF6, 5);
    wr(8'hF7, 8'h00);

    phase = "R4";
    wr(8'hF5, 8'h0A);
    wr(8'hF6, 8'd2);
    ticks(59);
    rd_chk("R4 before 60", 8'hF6, 2);
    ticks(1);
    rd_chk("R4 at 60", 8'hF6, 1);
    low_cnt = 0;
    ticks(60);
    idle(20);
    rd_chk("R4 expired", 8'hF6, 0);
    check("R4 pulse", low_cnt, 16);

    idle(4);
    finish_run();
  end
endmodule